// File: doc/BRIEF.md
# Multi-mode SPI word shifter

This block moves a burst of words across an SPI bus. When `start` is seen while the block is idle, it captures its settings from the input pins: the read and write enables, a word count, a per-word bit length, a clock divider and the clock polarity and phase. It then runs `word_cnt + 1` word slots. `sclk` is derived from the module clock through the divider. Transmit words come in on a valid/ready stream, and received words leave on another valid/ready stream.

Either direction can be switched off for a burst. Transmission is MSB first. When the length is shorter than the data width, the top bits of the word are sent and the received bits land right-aligned. The block waits before a word until a transmit word arrives, and after a word until the received word is taken. A single-cycle `done` pulse marks the end of the burst, and `sclk` is back at its idle level by then.

Top module: `spi_word_shifter`

## Requirements
- R1: While reset is asserted, `sclk`=0, `sdo`=0, `sdo_t`=1, `done`=0, `wr_ready`=0 and `rd_valid`=0.
- R2: A burst holds exactly `word_cnt`+1 words. `done` is high for exactly one cycle. That cycle is the one after the last word ends, where a word ends on its final `sclk` edge or, with read enabled, on its read handshake.
- R3: Each word has 2·L `sclk` edges spaced `clk_div`+1 clock cycles apart. The first edge comes `clk_div`+1 cycles after shifting starts. `sclk` changes only while shifting or while idle.
- R4: While idle, `sclk` equals the `cpol` input of the previous cycle. Settings are captured on the `start` cycle and held for the whole burst, so `sclk` rests at the captured `cpol` outside the shift phase.
- R5: With `cpha`=0, `sdi` is sampled on edges 0, 2, 4… and `sdo` changes on odd edges. With `cpha`=1, `sdi` is sampled on odd edges and `sdo` changes on even edges other than edge 0.
- R6: `sdo` carries the transmit word MSB first, starting with bit DATA_WIDTH-1, and only while shifting with write enabled. It is 0 at all other times.
- R7: With write enabled, `sdo_t` is 0 from the cycle after `start` through the `done` cycle. It is 1 at all other times.
- R8: With write enabled, `wr_ready` is high in each word's load phase and stays high until `wr_valid` is seen. Shifting begins the cycle after the handshake. Without write enabled, the load phase lasts one cycle and `wr_ready` stays low.
- R9: With read enabled, `rd_valid` rises the cycle after the last edge of a word. `rd_data` holds the L sampled bits right-aligned, with the first-sampled bit as the most significant of them and zeros above. Both are held until `rd_ready`.
- R10: The effective length L is `bit_len`, except that a `bit_len` of 0 or above DATA_WIDTH gives L = DATA_WIDTH.
- R11: `three_wire` follows `three_wire_cfg` one cycle late while idle and is frozen during a burst.
- R12: `start` pulses during a burst have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a burst (taken when idle) |
| rd_en | input | 1 | Receive words this burst |
| wr_en | input | 1 | Transmit words this burst |
| word_cnt | input | CNT_W | Words in burst minus one |
| bit_len | input | LEN_W | Bits per word (0 = DATA_WIDTH) |
| clk_div | input | DIV_W | Half-period of sclk minus one, in clocks |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | Sample on trailing edge when 1 |
| three_wire_cfg | input | 1 | Three-wire mode setting |
| wr_data | input | DATA_WIDTH | Transmit word |
| wr_valid | input | 1 | Transmit word available |
| wr_ready | output | 1 | Transmit word taken |
| rd_data | output | DATA_WIDTH | Received word |
| rd_valid | output | 1 | Received word available |
| rd_ready | input | 1 | Received word taken |
| sdi | input | 1 | Serial input |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial output |
| sdo_t | output | 1 | Output tristate control (0 = drive) |
| three_wire | output | 1 | Captured three-wire setting |
| done | output | 1 | Burst complete pulse |

## Verification
The hardest case to reach is a word that stalls at both boundaries in the same burst: a late transmit word, followed by a received word that is refused for several cycles. The stall must leave `sclk` parked at the idle level, with no extra edge.

The stimulus throttles `wr_valid` and `rd_ready` at random on every cycle across multi-word bursts. It does this with a divider above zero and with both phase settings. A behavioural model predicts every output on every cycle, and it waits on the same handshakes the stimulus produces.

// File: rtl/spi_ws_pkg.sv
package spi_ws_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_SHIFT,
      ST_PUSH,
      ST_DONE
   } ws_state_e;
endpackage

// File: rtl/spi_ws_prescaler.sv
// Half-period tick generator: one tick every (div+1) cycles while run is high.
module spi_ws_prescaler #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= div;
      else if (cnt == '0)   cnt <= div;
      else                  cnt <= cnt - 1'b1;
   end

   assign tick = run && (cnt == '0);
endmodule

// File: rtl/spi_ws_edgeseq.sv
// Counts sclk edges within a word and classifies each as sample or shift.
module spi_ws_edgeseq #(
   parameter int EDGE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic              cpha,
   input  logic [EDGE_W-1:0] last_idx,
   output logic              sample,
   output logic              shift,
   output logic              last,
   output logic              phase
);
   logic [EDGE_W-1:0] eidx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     eidx <= '0;
      else if (!run)  eidx <= '0;
      else if (tick)  eidx <= eidx + 1'b1;
   end

   assign phase  = eidx[0];
   assign sample = tick && (eidx[0] == cpha);
   assign shift  = tick && (eidx[0] != cpha) && (eidx != '0);
   assign last   = tick && (eidx == last_idx);
endmodule

// File: rtl/spi_ws_shifter.sv
// Transmit and receive shift registers, MSB first.
module spi_ws_shifter #(
   parameter int DATA_WIDTH = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [DATA_WIDTH-1:0] load_word,
   input  logic                  shift,
   input  logic                  sample,
   input  logic                  sdi,
   output logic                  tx_msb,
   output logic [DATA_WIDTH-1:0] rx_word
);
   logic [DATA_WIDTH-1:0] tx_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr   <= '0;
         rx_word <= '0;
      end else if (load) begin
         tx_sr   <= load_word;
         rx_word <= '0;
      end else begin
         if (shift)  tx_sr   <= {tx_sr[DATA_WIDTH-2:0], 1'b0};
         if (sample) rx_word <= {rx_word[DATA_WIDTH-2:0], sdi};
      end
   end

   assign tx_msb = tx_sr[DATA_WIDTH-1];
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
   parameter int DATA_WIDTH    = 8,
   parameter int CNT_W         = 8,
   parameter int DIV_W         = 8,
   parameter int LEN_W         = 8,
   parameter bit HAS_PRESCALER = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  rd_en,
   input  logic                  wr_en,
   input  logic [CNT_W-1:0]      word_cnt,
   input  logic [LEN_W-1:0]      bit_len,
   input  logic [DIV_W-1:0]      clk_div,
   input  logic                  cpol,
   input  logic                  cpha,
   input  logic                  three_wire_cfg,
   input  logic [DATA_WIDTH-1:0] wr_data,
   input  logic                  wr_valid,
   output logic                  wr_ready,
   output logic [DATA_WIDTH-1:0] rd_data,
   output logic                  rd_valid,
   input  logic                  rd_ready,
   input  logic                  sdi,
   output logic                  sclk,
   output logic                  sdo,
   output logic                  sdo_t,
   output logic                  three_wire,
   output logic                  done
);
   import spi_ws_pkg::*;

   localparam int EDGE_W = $clog2(2 * DATA_WIDTH) + 1;

   if (DATA_WIDTH < 2) begin : g_bad_width
      $error("spi_word_shifter: DATA_WIDTH must be at least 2");
   end
   if (CNT_W < 1 || DIV_W < 1 || LEN_W < 1) begin : g_bad_fields
      $error("spi_word_shifter: field widths must be positive");
   end

   ws_state_e         state;
   logic              rd_q, wr_q, cpol_q, cpha_q, tw_q;
   logic [CNT_W-1:0]  left_q;
   logic [DIV_W-1:0]  div_q;
   logic [EDGE_W-1:0] last_q, last_d;
   logic              run, tick, sample, shift, last, phase;
   logic              load, tx_msb;

   // R10: effective length
   always_comb begin
      if (bit_len == '0 || 32'(bit_len) > DATA_WIDTH)
         last_d = EDGE_W'(2 * DATA_WIDTH - 1);
      else
         last_d = EDGE_W'(32'(bit_len) * 2 - 1);
   end

   // settings follow the pins while idle, frozen once a burst starts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;  wr_q <= 1'b0;  cpol_q <= 1'b0;  cpha_q <= 1'b0;
         tw_q <= 1'b0;  div_q <= '0;   last_q <= '0;
      end else if (state == ST_IDLE) begin
         rd_q <= rd_en;  wr_q <= wr_en;  cpol_q <= cpol;  cpha_q <= cpha;
         tw_q <= three_wire_cfg;  div_q <= clk_div;  last_q <= last_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         left_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state  <= ST_LOAD;
               left_q <= word_cnt;
            end
            ST_LOAD: if (load) state <= ST_SHIFT;
            ST_SHIFT: if (last) begin
               if (rd_q)                state <= ST_PUSH;
               else if (left_q == '0)   state <= ST_DONE;
               else begin
                  state  <= ST_LOAD;
                  left_q <= left_q - 1'b1;
               end
            end
            ST_PUSH: if (rd_ready) begin
               if (left_q == '0) state <= ST_DONE;
               else begin
                  state  <= ST_LOAD;
                  left_q <= left_q - 1'b1;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign run  = (state == ST_SHIFT);
   assign load = (state == ST_LOAD) && (!wr_q || wr_valid);

   if (HAS_PRESCALER) begin : g_presc
      spi_ws_prescaler #(.DIV_W(DIV_W)) i_presc (
         .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
      );
   end else begin : g_nopresc
      assign tick = run;
   end

   spi_ws_edgeseq #(.EDGE_W(EDGE_W)) i_edges (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cpha(cpha_q),
      .last_idx(last_q), .sample(sample), .shift(shift), .last(last),
      .phase(phase)
   );

   spi_ws_shifter #(.DATA_WIDTH(DATA_WIDTH)) i_shift (
      .clk(clk), .rst_n(rst_n), .load(load),
      .load_word(wr_q ? wr_data : '0), .shift(shift), .sample(sample),
      .sdi(sdi), .tx_msb(tx_msb), .rx_word(rd_data)
   );

   assign wr_ready   = (state == ST_LOAD) && wr_q;
   assign rd_valid   = (state == ST_PUSH);
   assign sclk       = cpol_q ^ phase;
   assign sdo        = wr_q && run && tx_msb;
   assign sdo_t      = !(wr_q && state != ST_IDLE);
   assign three_wire = tw_q;
   assign done       = (state == ST_DONE);
endmodule

// File: rtl/spi_word_shifter_chk.sv
module spi_word_shifter_chk #(
   parameter int DATA_WIDTH = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_valid,
   input logic                  wr_ready,
   input logic                  rd_valid,
   input logic                  rd_ready,
   input logic [DATA_WIDTH-1:0] rd_data,
   input logic                  done,
   input logic                  sclk,
   input logic                  sdo,
   input logic                  sdo_t,
   input logic                  cpol_q,
   input spi_ws_pkg::ws_state_e state
);
   import spi_ws_pkg::*;

   p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready && !wr_valid |=> wr_ready);

   p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> sclk == cpol_q);

   p_sdo_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_t |-> !sdo);

   p_sclk_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk) |-> ($past(state) == ST_SHIFT || $past(state) == ST_IDLE));
endmodule

bind spi_word_shifter spi_word_shifter_chk #(.DATA_WIDTH(DATA_WIDTH)) i_chk (.*);

// File: tb/test_spi_word_shifter.sv
`timescale 1ns/1ps
module test_spi_word_shifter;
   localparam int DW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 0, rd_en = 0, wr_en = 0, cpol = 0, cpha = 0, tw_cfg = 0;
   logic [7:0] word_cnt = 0, bit_len = 0, clk_div = 0;
   logic [DW-1:0] wr_data = 0, rd_data;
   logic wr_valid = 0, wr_ready, rd_valid, rd_ready = 0, sdi = 0;
   logic sclk, sdo, sdo_t, three_wire, done;

   int checks = 0, failures = 0;
   bit finished = 0, stall_mode = 0;

   // expected outputs, updated by the model just after each rising edge
   logic e_sclk, e_sdo, e_sdo_t, e_wready, e_rvalid, e_done, e_tw;
   logic [DW-1:0] e_rdata;

   always #2.5 clk = ~clk;

   spi_word_shifter i_spi_word_shifter (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en), .wr_en(wr_en),
      .word_cnt(word_cnt), .bit_len(bit_len), .clk_div(clk_div), .cpol(cpol),
      .cpha(cpha), .three_wire_cfg(tw_cfg), .wr_data(wr_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .sdi(sdi), .sclk(sclk),
      .sdo(sdo), .sdo_t(sdo_t), .three_wire(three_wire), .done(done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   task automatic model_reset();
      e_sclk = 0; e_sdo = 0; e_sdo_t = 1; e_wready = 0; e_rvalid = 0;
      e_done = 0; e_tw = 0; e_rdata = '0;
   endtask

   task automatic tick_edge();
      @(posedge clk); #1;
   endtask

   // behavioural reference: walks a burst word by word, edge by edge
   task automatic model_burst(input bit m_rd, m_wr, m_pol, m_pha,
                              input int m_cnt, m_len, m_div);
      logic [DW-1:0] word, rxw;
      int L;
      L = (m_len == 0 || m_len > DW) ? DW : m_len;   // R10
      e_sdo_t = !m_wr;                                 // R7
      for (int w = 0; w <= m_cnt; w++) begin
         e_wready = m_wr; e_sdo = 0; e_rvalid = 0; e_sclk = m_pol;
         forever begin
            tick_edge();
            if (!m_wr || wr_valid) break;
         end
         word = m_wr ? wr_data : '0;
         e_wready = 0;
         rxw = '0;
         for (int k = 0; k < 2 * L; k++) begin
            e_sclk = m_pol ^ k[0];
            e_sdo  = m_wr & word[DW-1];
            repeat (m_div + 1) tick_edge();
            if ((k % 2) == int'(m_pha)) rxw = {rxw[DW-2:0], sdi};
            else if (!(m_pha && k == 0)) word = word << 1;
         end
         e_sclk = m_pol; e_sdo = 0;
         if (m_rd) begin
            e_rvalid = 1; e_rdata = rxw;
            forever begin
               tick_edge();
               if (rd_ready) break;
            end
            e_rvalid = 0;
         end
      end
      e_done = 1;
      tick_edge();
      e_done = 0; e_sdo_t = 1;
   endtask

   initial begin : model
      model_reset();
      forever begin
         tick_edge();
         if (!rst_n) begin
            model_reset();
         end else begin
            e_sclk = cpol; e_tw = tw_cfg; e_done = 0;   // R4 R11
            if (start)
               model_burst(rd_en, wr_en, cpol, cpha, int'(word_cnt),
                           int'(bit_len), int'(clk_div));
         end
      end
   end

   // compare every cycle away from the edge, then drive stream inputs
   initial begin : cmp_drive
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            chk("R1 sclk", sclk, 0);       chk("R1 sdo", sdo, 0);
            chk("R1 sdo_t", sdo_t, 1);     chk("R1 done", done, 0);
            chk("R1 wr_ready", wr_ready, 0); chk("R1 rd_valid", rd_valid, 0);
         end else begin
            chk("R3 R4 sclk", sclk, e_sclk);
            chk("R5 R6 R10 sdo", sdo, e_sdo);
            chk("R7 sdo_t", sdo_t, e_sdo_t);
            chk("R8 wr_ready", wr_ready, e_wready);
            chk("R9 rd_valid", rd_valid, e_rvalid);
            if (e_rvalid) chk("R5 R9 R10 rd_data", rd_data, e_rdata);
            chk("R2 R12 done", done, e_done);
            chk("R11 three_wire", three_wire, e_tw);
         end
         wr_valid = stall_mode ? ($urandom % 3 != 0) : 1'b1;
         rd_ready = stall_mode ? ($urandom % 3 == 0) : 1'b1;
         wr_data  = DW'($urandom);
         sdi      = 1'($urandom);
      end
   end

   task automatic run_xfer(input bit rd, wr, pol, pha, tw, stall, poke,
                           input int cnt, len, div);
      @(negedge clk);
      rd_en = rd; wr_en = wr; cpol = pol; cpha = pha; tw_cfg = tw;
      word_cnt = 8'(cnt); bit_len = 8'(len); clk_div = 8'(div);
      stall_mode = stall;
      repeat (2) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
      if (poke) begin                       // R12: start during burst
         repeat (4) @(negedge clk);
         start = 1;
         @(negedge clk);
         start = 0;
      end
      forever begin
         @(negedge clk);
         if (done) break;
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R2 R5 R6 R9: single word, mode 0
      run_xfer(1, 1, 0, 0, 0, 0, 0, 0, 8, 0);
      // R3 R4 R8 R9: stalls, divider 2, high idle clock
      run_xfer(1, 1, 1, 0, 0, 1, 1, 3, 8, 2);
      // R5 R6 R10: write only, short words, cpha 1
      run_xfer(0, 1, 0, 1, 1, 0, 0, 2, 5, 1);
      // R9 R10: read only, 3-bit words, cpol 1 cpha 1, stalls
      run_xfer(1, 0, 1, 1, 0, 1, 0, 1, 3, 0);
      // R7 R10: neither direction, length 0 means full width
      run_xfer(0, 0, 0, 0, 1, 0, 1, 1, 0, 1);
      // R10: oversize length, cpha 1, divider 3, stalls
      run_xfer(1, 1, 0, 1, 0, 1, 0, 2, 12, 3);
      // R11 R12: three-wire set, mode 3 with single-bit words
      run_xfer(1, 1, 1, 1, 1, 1, 1, 4, 1, 1);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule